// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits between a host-side configuration request path and the PCI bus master of a host bridge. Each request carries the 24-bit logical configuration address that software placed in the configuration-address I/O port, plus a read/write flag and an access size. The block decides whether the access belongs to one of the bridge's own functions or must go out on PCI. For outside targets it builds the address-phase AD word and chooses the configuration cycle type. For bridge functions it steers the access to the right function, and it applies the enable that hides the delay-line function.

The logical address is laid out as bus number in bits 23:16, device in 15:11, function in 10:8, doubleword register index in 7:2 and byte offset in 1:0. The bridge itself is device 0 (host bridge at function 0, a delay-line tuning function at function 1) and device 1 (PCI-to-PCI bridge at function 0), both on bus 0. A response appears one clock after each request, as a route code with byte enables and either an outgoing AD word or a one-hot internal select. Accesses that end in a master abort, and reads of the hidden function's reserved header, are flagged so that the read data is all ones.

Top module: `cfg_xlate`

## Requirements
- R1: A request presented with req_valid high on a clock edge produces rsp_valid high on the following edge, together with the route code (0 external, 1 host bridge, 2 delay-line function, 3 PCI-to-PCI bridge, 4 master abort, 5 delay-line reserved header, 6 ignored, 7 misaligned). When no request was presented, rsp_valid, ext_valid, int_sel, rsp_ones, rsp_err and rsp_be are all zero.
- R2: The size code (0 byte, 1 word, 2 doubleword, 3 illegal) must be naturally aligned: a word needs byte offset 0 or 2 and a doubleword needs offset 0. A misaligned or illegal request gets route 7, rsp_err high, rsp_be zero, no external cycle and no internal select.
- R3: For an aligned request, rsp_be (active high, bit n = byte lane n) is 0001 shifted left by the offset for a byte, 0011 shifted left by the offset for a word, and 1111 for a doubleword.
- R4: On bus 0 with device 2 to 20, an external type 0 cycle is issued: ext_type1 low, AD[1:0] = 00, AD[11+device] the only bit set in AD[31:11], AD[10:8] = function, AD[7:2] = register index.
- R5: With a nonzero bus number, an external type 1 cycle is issued for any device: ext_type1 high, AD[31:24] = 0, AD[23:16] = bus, AD[15:11] = device, AD[10:8] = function, AD[7:2] = register index, AD[1:0] = 01.
- R6: On bus 0, device 0 function 0 gets route 1 with int_sel = 001, and device 1 function 0 gets route 3 with int_sel = 100; neither issues an external cycle.
- R7: On bus 0, device 0 function 1 with f1_enable low gets route 6 with no internal select, no external cycle and rsp_ones low.
- R8: On bus 0, device 0 function 1 with f1_enable high goes to route 5 for register indices 0 to 15, where a read has rsp_ones high and a write reaches nothing; register indices 16 and up go to route 2 with int_sel = 010.
- R9: On bus 0, devices 21 to 31 and the unimplemented functions of devices 0 and 1 get route 4; a read has rsp_ones high, a write is dropped, and no external cycle or internal select is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 24 | Logical configuration address (bus, device, function, register, offset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| f1_enable | input | 1 | Control bit that exposes device 0 function 1 |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_route | output | 3 | Route code |
| rsp_write | output | 1 | Registered copy of the write flag |
| rsp_err | output | 1 | Misaligned or illegal size |
| rsp_ones | output | 1 | Read completes with all-ones data |
| rsp_be | output | 4 | Active-high byte enables |
| ext_valid | output | 1 | An external configuration cycle is to be issued |
| ext_type1 | output | 1 | 1 = type 1 cycle, 0 = type 0 cycle |
| ext_ad | output | 32 | Address-phase AD value |
| int_sel | output | 3 | One-hot internal function select (host, delay-line, PCI-to-PCI) |

## Verification
The hardest corner to reach is the hidden delay-line function: its behaviour depends at once on the enable bit, the register index falling below or above the reserved header, the direction, and the alignment check taking precedence over all of it. The bench reaches it by sweeping every device and function on bus 0 and on two nonzero buses, crossed with both enable values, register indices on either side of the header limit, every offset, every size code and both directions, and comparing each response against a model computed from the address fields.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

    localparam int ADDR_W    = 24;
    localparam int BUS_W     = 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int REG_W     = 6;
    localparam int OFF_W     = 2;
    localparam int AD_W      = 32;
    localparam int BE_W      = 4;
    localparam int IDSEL_LSB = 11;
    localparam int SEL_W     = 3;

    // highest device number that still owns an IDSEL line
    localparam int MAX_IDSEL_DEV = AD_W - 1 - IDSEL_LSB;

    // bridge-owned device and function numbers
    localparam logic [DEV_W-1:0] HOST_DEV = 5'd0;
    localparam logic [DEV_W-1:0] P2P_DEV  = 5'd1;
    localparam logic [FN_W-1:0]  BASE_FN  = 3'd0;
    localparam logic [FN_W-1:0]  TUNE_FN  = 3'd1;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        RT_EXT      = 3'd0,
        RT_HOST     = 3'd1,
        RT_TUNE     = 3'd2,
        RT_P2P      = 3'd3,
        RT_ABORT    = 3'd4,
        RT_TUNE_HDR = 3'd5,
        RT_IGNORE   = 3'd6,
        RT_MISALIGN = 3'd7
    } route_e;

    // field layout matches the logical address word, msb first
    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic [DEV_W-1:0] dev;
        logic [FN_W-1:0]  fn;
        logic [REG_W-1:0] dw;
        logic [OFF_W-1:0] off;
    } cfg_addr_t;

    typedef struct packed {
        logic             valid;
        route_e           route;
        logic             write;
        logic             err;
        logic             ones;
        logic [BE_W-1:0]  be;
        logic             ext_valid;
        logic             ext_type1;
        logic [AD_W-1:0]  ad;
        logic [SEL_W-1:0] sel;
    } cfg_rsp_t;

    // lane mask of an access size before shifting by the offset
    function automatic logic [BE_W-1:0] lane_mask(size_e sz);
        case (sz)
            SZ_BYTE:  return 4'b0001;
            SZ_WORD:  return 4'b0011;
            SZ_DWORD: return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

    // natural alignment: offset bits below the size must be zero
    function automatic logic is_aligned(size_e sz, logic [OFF_W-1:0] off);
        case (sz)
            SZ_BYTE:  return 1'b1;
            SZ_WORD:  return ~off[0];
            SZ_DWORD: return off == '0;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] route_sel(route_e rt);
        case (rt)
            RT_HOST: return 3'b001;
            RT_TUNE: return 3'b010;
            RT_P2P:  return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_align_chk.sv
module cfg_align_chk
    import cfg_xlate_pkg::*;
(
    input  size_e            size,
    input  logic [OFF_W-1:0] off,
    output logic [BE_W-1:0]  be,
    output logic             bad
);
    logic ok;

    always_comb begin
        ok  = is_aligned(size, off);
        bad = ~ok;
        be  = ok ? (lane_mask(size) << off) : '0;
    end

endmodule

// File: rtl/cfg_target_dec.sv
module cfg_target_dec
    import cfg_xlate_pkg::*;
#(
    parameter int HDR_DWORDS = 16
) (
    input  cfg_addr_t        addr,
    input  logic             write,
    input  logic             tune_en,
    input  logic             bad,
    output route_e           route,
    output logic [SEL_W-1:0] sel,
    output logic             ones
);
    localparam logic [REG_W-1:0] HDR_LIMIT = REG_W'(HDR_DWORDS);

    logic on_bus0;
    logic is_host_dev;
    logic is_p2p_dev;
    logic has_idsel;

    always_comb begin
        on_bus0     = addr.bus == '0;
        is_host_dev = addr.dev == HOST_DEV;
        is_p2p_dev  = addr.dev == P2P_DEV;
        has_idsel   = addr.dev <= DEV_W'(MAX_IDSEL_DEV);

        if (bad) begin
            route = RT_MISALIGN;
        end else if (!on_bus0) begin
            route = RT_EXT;
        end else if (is_host_dev) begin
            if (addr.fn == BASE_FN)
                route = RT_HOST;
            else if (addr.fn == TUNE_FN)
                route = !tune_en            ? RT_IGNORE :
                        (addr.dw < HDR_LIMIT) ? RT_TUNE_HDR : RT_TUNE;
            else
                route = RT_ABORT;
        end else if (is_p2p_dev) begin
            route = (addr.fn == BASE_FN) ? RT_P2P : RT_ABORT;
        end else if (!has_idsel) begin
            route = RT_ABORT;
        end else begin
            route = RT_EXT;
        end

        sel  = route_sel(route);
        ones = ~write & ((route == RT_ABORT) | (route == RT_TUNE_HDR));
    end

endmodule

// File: rtl/cfg_ad_build.sv
module cfg_ad_build
    import cfg_xlate_pkg::*;
(
    input  cfg_addr_t       addr,
    input  route_e          route,
    output logic            ext_valid,
    output logic            ext_type1,
    output logic [AD_W-1:0] ad
);
    localparam int IDSEL_N = AD_W - IDSEL_LSB;

    logic [IDSEL_N-1:0] idsel;
    logic [AD_W-1:0]    ad_t0;
    logic [AD_W-1:0]    ad_t1;

    // one comparator per IDSEL line
    for (genvar b = 0; b < IDSEL_N; b++) begin : g_idsel
        assign idsel[b] = addr.dev == DEV_W'(b);
    end

    always_comb begin
        ad_t0 = {idsel, addr.fn, addr.dw, 2'b00};
        ad_t1 = {{(AD_W - ADDR_W){1'b0}}, addr.bus, addr.dev, addr.fn, addr.dw, 2'b01};

        ext_valid = route == RT_EXT;
        ext_type1 = ext_valid & (addr.bus != '0);
        if (!ext_valid)
            ad = '0;
        else if (ext_type1)
            ad = ad_t1;
        else
            ad = ad_t0;
    end

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfg_xlate_pkg::*;
#(
    parameter int HDR_DWORDS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [23:0] req_addr,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        f1_enable,
    output logic        rsp_valid,
    output logic [2:0]  rsp_route,
    output logic        rsp_write,
    output logic        rsp_err,
    output logic        rsp_ones,
    output logic [3:0]  rsp_be,
    output logic        ext_valid,
    output logic        ext_type1,
    output logic [31:0] ext_ad,
    output logic [2:0]  int_sel
);
    cfg_addr_t        addr;
    size_e            size;
    logic [BE_W-1:0]  be_c;
    logic             bad_c;
    route_e           route_c;
    logic [SEL_W-1:0] sel_c;
    logic             ones_c;
    logic             xv_c;
    logic             xt1_c;
    logic [AD_W-1:0]  ad_c;
    cfg_rsp_t         nxt;
    cfg_rsp_t         rsp_q;

    assign addr = cfg_addr_t'(req_addr);
    assign size = size_e'(req_size);

    cfg_align_chk u_align (
        .size (size),
        .off  (addr.off),
        .be   (be_c),
        .bad  (bad_c)
    );

    cfg_target_dec #(.HDR_DWORDS(HDR_DWORDS)) u_dec (
        .addr    (addr),
        .write   (req_write),
        .tune_en (f1_enable),
        .bad     (bad_c),
        .route   (route_c),
        .sel     (sel_c),
        .ones    (ones_c)
    );

    cfg_ad_build u_ad (
        .addr      (addr),
        .route     (route_c),
        .ext_valid (xv_c),
        .ext_type1 (xt1_c),
        .ad        (ad_c)
    );

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            nxt.valid     = 1'b1;
            nxt.route     = route_c;
            nxt.write     = req_write;
            nxt.err       = bad_c;
            nxt.ones      = ones_c;
            nxt.be        = be_c;
            nxt.ext_valid = xv_c;
            nxt.ext_type1 = xt1_c;
            nxt.ad        = ad_c;
            nxt.sel       = sel_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= nxt;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_route = rsp_q.route;
    assign rsp_write = rsp_q.write;
    assign rsp_err   = rsp_q.err;
    assign rsp_ones  = rsp_q.ones;
    assign rsp_be    = rsp_q.be;
    assign ext_valid = rsp_q.ext_valid;
    assign ext_type1 = rsp_q.ext_type1;
    assign ext_ad    = rsp_q.ad;
    assign int_sel   = rsp_q.sel;

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic [2:0]  rsp_route,
    input logic        rsp_write,
    input logic        rsp_err,
    input logic        rsp_ones,
    input logic [3:0]  rsp_be,
    input logic        ext_valid,
    input logic        ext_type1,
    input logic [31:0] ext_ad,
    input logic [2:0]  int_sel
);
    a_r1_follows_request: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!ext_valid && int_sel == 3'b000 && !rsp_ones && !rsp_err && rsp_be == 4'h0));

    a_r2_misalign_blocked: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_route == 3'd7 && !ext_valid && int_sel == 3'b000 && rsp_be == 4'h0));

    a_r4_type0_shape: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && !ext_type1) |-> (ext_ad[1:0] == 2'b00 && $onehot(ext_ad[31:13]) && ext_ad[12:11] == 2'b00));

    a_r5_type1_shape: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && ext_type1) |-> (ext_ad[31:24] == 8'h00 && ext_ad[23:16] != 8'h00 && ext_ad[1:0] == 2'b01));

    a_r6_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(int_sel) && !(ext_valid && int_sel != 3'b000));

    a_r7_ignored_quiet: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_route == 3'd6) |-> (!rsp_ones && int_sel == 3'b000 && !ext_valid));

    a_r9_ones_read_only: assert property (@(posedge clk) disable iff (rst)
        rsp_ones |-> (!rsp_write && !ext_valid && int_sel == 3'b000));

endmodule

bind cfg_xlate cfg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_route (rsp_route),
    .rsp_write (rsp_write),
    .rsp_err   (rsp_err),
    .rsp_ones  (rsp_ones),
    .rsp_be    (rsp_be),
    .ext_valid (ext_valid),
    .ext_type1 (ext_type1),
    .ext_ad    (ext_ad),
    .int_sel   (int_sel)
);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic        f1_enable = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_route;
    logic        rsp_write;
    logic        rsp_err;
    logic        rsp_ones;
    logic [3:0]  rsp_be;
    logic        ext_valid;
    logic        ext_type1;
    logic [31:0] ext_ad;
    logic [2:0]  int_sel;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cfg_xlate u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_addr (req_addr),
        .req_write (req_write), .req_size (req_size), .f1_enable (f1_enable),
        .rsp_valid (rsp_valid), .rsp_route (rsp_route), .rsp_write (rsp_write),
        .rsp_err (rsp_err), .rsp_ones (rsp_ones), .rsp_be (rsp_be),
        .ext_valid (ext_valid), .ext_type1 (ext_type1), .ext_ad (ext_ad),
        .int_sel (int_sel)
    );

    // packed view of every response port, valid first
    function automatic logic [48:0] pack_out();
        return {rsp_valid, rsp_route, rsp_write, rsp_err, rsp_ones, rsp_be,
                ext_valid, ext_type1, ext_ad, int_sel};
    endfunction

    function automatic logic [48:0] pack_exp(logic v, logic [2:0] rt, logic w, logic e,
                                             logic o, logic [3:0] be, logic xv, logic x1,
                                             logic [31:0] ad, logic [2:0] s);
        return {v, rt, w, e, o, be, xv, x1, ad, s};
    endfunction

    task automatic check(string tag, logic [48:0] exp);
        logic [48:0] act;
        act = pack_out();
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h size=%0d wr=%0d en=%0d actual=%h expected=%h",
                     tag, req_addr, req_size, req_write, f1_enable, act, exp);
        end
    endtask

    // reference: computed from the address fields and the requirement text
    task automatic run_vector(logic [7:0] bus, int dev, int fn, int dw, int off,
                              int sz, logic wr, logic en);
        int          rt;
        logic [3:0]  be;
        logic        err;
        logic        ones;
        logic        xv;
        logic        x1;
        logic [31:0] ad;
        logic [2:0]  sel;
        string       tag;

        req_valid = 1'b1;
        req_addr  = {bus, 5'(dev), 3'(fn), 6'(dw), 2'(off)};
        req_size  = 2'(sz);
        req_write = wr;
        f1_enable = en;

        // R2 / R3: alignment and byte lanes
        err = (sz == 3) || (sz == 1 && (off % 2) != 0) || (sz == 2 && off != 0);
        if (err)          be = 4'h0;
        else if (sz == 0) be = 4'(1 << off);
        else if (sz == 1) be = 4'(3 << off);
        else              be = 4'hF;

        if (err)                          begin rt = 7; tag = "R2"; end
        else if (bus != 0)                begin rt = 0; tag = "R5"; end
        else if (dev == 0 && fn == 0)     begin rt = 1; tag = "R6"; end
        else if (dev == 1 && fn == 0)     begin rt = 3; tag = "R6"; end
        else if (dev == 0 && fn == 1 && !en) begin rt = 6; tag = "R7"; end
        else if (dev == 0 && fn == 1)     begin rt = (dw < 16) ? 5 : 2; tag = "R8"; end
        else if (dev < 2 || dev > 20)     begin rt = 4; tag = "R9"; end
        else                              begin rt = 0; tag = "R4"; end

        ones = !wr && (rt == 4 || rt == 5);
        xv   = (rt == 0);
        x1   = xv && (bus != 0);
        sel  = (rt == 1) ? 3'b001 : (rt == 2) ? 3'b010 : (rt == 3) ? 3'b100 : 3'b000;
        if (!xv)     ad = 32'h0;
        else if (x1) ad = (32'(bus) << 16) + (32'(dev) << 11) + (32'(fn) << 8) + (32'(dw) << 2) + 32'd1;
        else         ad = (32'd1 << (11 + dev)) + (32'(fn) << 8) + (32'(dw) << 2);

        @(posedge clk);
        @(negedge clk);
        if (!err && rsp_be !== be) tag = "R3";
        check(tag, pack_exp(1'b1, 3'(rt), wr, err, ones, be, xv, x1, ad, sel));
    endtask

    initial begin
        logic [7:0] buses [3];
        int         dws [2];
        buses[0] = 8'h00; buses[1] = 8'h01; buses[2] = 8'hA5;
        dws[0] = 5; dws[1] = 16;

        repeat (3) @(negedge clk);
        check("R1 reset", 49'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle", 49'h0);

        for (int b = 0; b < 3; b++)
            for (int d = 0; d < 32; d++)
                for (int f = 0; f < 8; f++)
                    for (int r = 0; r < 2; r++)
                        for (int o = 0; o < 4; o++)
                            for (int s = 0; s < 4; s++)
                                for (int w = 0; w < 2; w++)
                                    for (int e = 0; e < 2; e++)
                                        run_vector(buses[b], d, f, dws[r], o, s, w[0], e[0]);

        // R1: response drops once requests stop
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 drop", 49'h0);

        // R1: reset mid-stream clears a pending response
        run_vector(8'h00, 5, 2, 9, 0, 2, 1'b0, 1'b0);
        req_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset clears", 49'h0);
        rst = 1'b0;
        req_valid = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule